// File: doc/BRIEF.md
# Masked Vector Expand Unit

This block takes a densely packed vector of 64-bit elements and spreads them across the lanes of a destination vector selected by an 8-bit mask. The lowest dense element goes to the lowest selected lane, the next one to the next selected lane, and so on upward. Lanes that are not selected either keep the previous destination value (merge) or are written with zero (zero mode). Everything above the active vector length is cleared.

A request is offered with a single-cycle `in_valid` strobe. One cycle later the block presents a registered result with a one-cycle `out_valid` pulse, along with how many dense elements were consumed, an illegal-encoding flag, and a byte offset derived from an 8-bit displacement scaled by the element size. A reserved 4-bit field must be all ones. Any other value marks the request illegal and leaves the destination untouched.

Top module: `vec_expand_unit`

## Requirements
- R1: `vl_sel` picks the active lane count. A value of 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), and both 2 and 3 give 8 lanes (512 bits). Lane j occupies result bits [64*j+63 : 64*j].
- R2: With `mask_en`=1, an active lane j whose `mask[j]` is set receives source element e, where e is the number of set mask bits in active lanes below j. Source element e occupies `src_vec` bits [64*e+63 : 64*e].
- R3: With `mask_en`=0 the mask is disregarded and every active lane is selected, so the result holds the first KL source elements in order.
- R4: With `zero_mode`=0, an unselected active lane keeps the matching 64 bits of `old_dst`.
- R5: With `zero_mode`=1, an unselected active lane reads as zero.
- R6: On a legal request, all result bits from 64*KL up to bit 511 are zero, whatever the mask and `old_dst` hold.
- R7: When `rsv_field` is not 4'b1111, `illegal` is 1, `result` equals the full `old_dst`, and `consumed` is 0. Otherwise `illegal` is 0.
- R8: `eff_offset` is the 8-bit `disp`, read as two's complement, multiplied by 8 and given as an 11-bit two's complement value. This holds on every request, legal or not.
- R9: Mask bits at positions KL and above change neither the result nor `consumed`.
- R10: On a legal request, `consumed` is the number of set mask bits among the active lanes, or KL when `mask_en`=0.
- R11: Each `in_valid` cycle produces `out_valid` high in exactly the next cycle. `out_valid` stays low otherwise. The outputs hold their values between results. Reset clears `out_valid`, `result`, `illegal`, `consumed` and `eff_offset` to zero.
- R12: An all-zero mask with `mask_en`=1 returns `old_dst` in the active lanes (merge) or zeros (zero mode), and `consumed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Dense source elements, element 0 in the lowest bits |
| mask | input | 8 | Lane selection mask, bit j for lane j |
| mask_en | input | 1 | 1: use the mask. 0: select all active lanes |
| zero_mode | input | 1 | 1: zero unselected lanes. 0: merge from old_dst |
| vl_sel | input | 2 | Vector length select |
| old_dst | input | 512 | Previous destination value |
| rsv_field | input | 4 | Reserved field, must be 4'b1111 |
| disp | input | 8 | Signed displacement in elements |
| out_valid | output | 1 | Result strobe, one cycle per request |
| result | output | 512 | Expanded destination vector |
| illegal | output | 1 | Reserved field was not all ones |
| consumed | output | 4 | Dense elements consumed |
| eff_offset | output | 11 | disp times 8, two's complement bytes |

## Verification
Legality and length clearing can act on the same request. The bench sends requests that have a bad reserved field, a short vector length and an `old_dst` whose upper lanes are nonzero. The illegal check must win: the full `old_dst`, upper bits included, has to come back with `consumed` equal to 0. Back-to-back requests, and masks with set bits above KL, are mixed with legal ones. A scoreboard predicts every field from the requirements and compares each result in the cycle it appears.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

  typedef enum logic [1:0] {
    VL_SHORT = 2'd0,
    VL_MID   = 2'd1,
    VL_FULL  = 2'd2,
    VL_ALT   = 2'd3
  } vlen_e;

  // number of active lanes for a length code, given the widest lane count
  function automatic int unsigned active_lanes(input logic [1:0] code,
                                               input int unsigned max_l);
    case (code)
      VL_SHORT: return max_l / 4;
      VL_MID:   return max_l / 2;
      default:  return max_l;
    endcase
  endfunction

endpackage

// File: rtl/vexp_prefix.sv
// Exclusive prefix population count over the lane pick vector.
module vexp_prefix #(
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(LANES),
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]             pick,
  output logic [LANES-1:0][IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]             total
);
  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int j = 0; j < LANES; j++) begin
      idx[j] = run[IDX_W-1:0];
      run = run + CNT_W'(pick[j]);
    end
    total = run;
  end
endmodule

// File: rtl/vexp_route.sv
// Per-lane routing: picked lanes take the indexed source element,
// unpicked active lanes merge or zero, inactive lanes clear.
module vexp_route #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int IDX_W  = $clog2(LANES),
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0]             src,
  input  logic [VEC_W-1:0]             prev,
  input  logic [LANES-1:0][IDX_W-1:0]  idx,
  input  logic [LANES-1:0]             pick,
  input  logic [LANES-1:0]             act,
  input  logic                         zero_mode,
  output logic [VEC_W-1:0]             dout
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] routed;
    assign routed = src[idx[j]*LANE_W +: LANE_W];
    always_comb begin
      if (!act[j])       dout[j*LANE_W +: LANE_W] = '0;
      else if (pick[j])  dout[j*LANE_W +: LANE_W] = routed;
      else if (zero_mode) dout[j*LANE_W +: LANE_W] = '0;
      else               dout[j*LANE_W +: LANE_W] = prev[j*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/vec_expand_unit.sv
module vec_expand_unit
  import vexp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int DISP_W = 8,
  parameter int RSV_W  = 4,
  localparam int VEC_W = LANES * LANE_W,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int ELEM_SH = $clog2(LANE_W / 8),
  localparam int OFF_W = DISP_W + ELEM_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [LANES-1:0]  mask,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [1:0]        vl_sel,
  input  logic [VEC_W-1:0]  old_dst,
  input  logic [RSV_W-1:0]  rsv_field,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic              illegal,
  output logic [CNT_W-1:0]  consumed,
  output logic [OFF_W-1:0]  eff_offset
);

  logic [LANES-1:0]            act;
  logic [LANES-1:0]            pick;
  logic [LANES-1:0][IDX_W-1:0] idx;
  logic [CNT_W-1:0]            total;
  logic [VEC_W-1:0]            expanded;
  logic                        bad_enc;
  int unsigned                 n_act;

  assign n_act   = active_lanes(vl_sel, LANES);
  assign bad_enc = (rsv_field != '1);

  always_comb begin
    for (int j = 0; j < LANES; j++) act[j] = (j < n_act);
  end

  assign pick = mask_en ? (mask & act) : act;

  vexp_prefix #(.LANES(LANES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_prefix (
    .pick  (pick),
    .idx   (idx),
    .total (total)
  );

  vexp_route #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_route (
    .src       (src_vec),
    .prev      (old_dst),
    .idx       (idx),
    .pick      (pick),
    .act       (act),
    .zero_mode (zero_mode),
    .dout      (expanded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      illegal    <= 1'b0;
      consumed   <= '0;
      eff_offset <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal    <= bad_enc;
        result     <= bad_enc ? old_dst : expanded;
        consumed   <= bad_enc ? '0 : total;
        eff_offset <= {disp, {ELEM_SH{1'b0}}};
      end
    end
  end

  // ---------------- assertions ----------------
  function automatic logic [VEC_W-1:0] keep_bits(input logic [1:0] code);
    logic [VEC_W-1:0] m;
    m = '0;
    for (int j = 0; j < LANES; j++)
      if (j < active_lanes(code, LANES)) m[j*LANE_W +: LANE_W] = '1;
    return m;
  endfunction

  assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_strobe_cause_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_illegal_keeps_dst_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == $past(old_dst) && consumed == '0));

  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |-> ((result & ~keep_bits($past(vl_sel))) == '0));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal) |->
      (32'(consumed) <= active_lanes($past(vl_sel), LANES)));

  assert_offset_scale_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |->
      ($signed(eff_offset) == $signed(OFF_W'($signed($past(disp)))) * (LANE_W / 8)));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !out_valid) |=> $stable(result));

endmodule

// File: tb/vec_expand_unit_test.sv
module vec_expand_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [511:0] res;
    logic         ill;
    logic [3:0]   cnt;
    logic [10:0]  off;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] src_vec = '0;
  logic [7:0]   mask = '0;
  logic         mask_en = 1'b0;
  logic         zero_mode = 1'b0;
  logic [1:0]   vl_sel = '0;
  logic [511:0] old_dst = '0;
  logic [3:0]   rsv_field = 4'hF;
  logic [7:0]   disp = '0;
  logic         out_valid;
  logic [511:0] result;
  logic         illegal;
  logic [3:0]   consumed;
  logic [10:0]  eff_offset;

  int total = 0;
  int bad = 0;
  int sent = 0;
  int seen = 0;
  exp_t q[$];
  exp_t last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_expand_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .vl_sel(vl_sel),
    .old_dst(old_dst), .rsv_field(rsv_field), .disp(disp),
    .out_valid(out_valid), .result(result), .illegal(illegal),
    .consumed(consumed), .eff_offset(eff_offset)
  );

  task automatic check(input bit ok, input string what, input string act_s, input string exp_s);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", what, act_s, exp_s);
    end
  endtask

  function automatic logic [511:0] pattern(input int seed);
    logic [511:0] v;
    for (int k = 0; k < 8; k++)
      v[k*64 +: 64] = {32'h5EED0000 + 32'(seed), 32'h00000100 + 32'(k)};
    return v;
  endfunction

  // model written from the requirements
  function automatic exp_t predict(input logic [511:0] s, input logic [7:0] m,
      input logic me, input logic zm, input logic [1:0] vl,
      input logic [511:0] od, input logic [3:0] rf, input logic [7:0] d, input string tag);
    exp_t e;
    int kl, ptr, dv;
    kl = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    dv = $signed(d);
    e.off = 11'(dv * 8);
    e.tag = tag;
    if (rf != 4'b1111) begin
      e.res = od; e.ill = 1'b1; e.cnt = 0;
      return e;
    end
    e.ill = 1'b0;
    e.res = '0;
    ptr = 0;
    for (int j = 0; j < kl; j++) begin
      if (!me || m[j]) begin
        e.res[j*64 +: 64] = s[ptr*64 +: 64];
        ptr++;
      end else if (!zm) begin
        e.res[j*64 +: 64] = od[j*64 +: 64];
      end
    end
    e.cnt = 4'(ptr);
    return e;
  endfunction

  task automatic send(input logic [511:0] s, input logic [7:0] m, input logic me,
      input logic zm, input logic [1:0] vl, input logic [511:0] od,
      input logic [3:0] rf, input logic [7:0] d, input string tag);
    @(negedge clk);
    src_vec = s; mask = m; mask_en = me; zero_mode = zm; vl_sel = vl;
    old_dst = od; rsv_field = rf; disp = d; in_valid = 1'b1;
    q.push_back(predict(s, m, me, zm, vl, od, rf, d, tag));
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      seen++;
      if (q.size() == 0) begin
        check(1'b0, "R11 unexpected out_valid", "1", "0");
      end else begin
        e = q.pop_front();
        last_exp = e;
        check(result == e.res, {e.tag, " result"}, $sformatf("%h", result), $sformatf("%h", e.res));
        check(illegal == e.ill, {e.tag, " illegal R7"}, $sformatf("%0d", illegal), $sformatf("%0d", e.ill));
        check(consumed == e.cnt, {e.tag, " consumed R10"}, $sformatf("%0d", consumed), $sformatf("%0d", e.cnt));
        check(eff_offset == e.off, {e.tag, " offset R8"}, $sformatf("%h", eff_offset), $sformatf("%h", e.off));
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog timeout", "running", "done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] od_a, od_b;
    od_a = {8{64'hDDDD_0000_0000_0000}} | pattern(99);
    od_b = {8{64'hFFFF_FFFF_FFFF_FFFF}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(out_valid == 0 && result == '0 && illegal == 0 && consumed == 0 && eff_offset == 0,
          "R11 reset state", $sformatf("%0d/%0d", out_valid, consumed), "0/0");

    send(pattern(1), 8'b1010_0101, 1, 0, 2'd2, od_a, 4'hF, 8'd3,  "R2 R4 sparse merge 512");
    send(pattern(2), 8'b1010_0101, 1, 1, 2'd2, od_a, 4'hF, 8'hFF, "R2 R5 sparse zero 512");
    send(pattern(3), 8'h00,        0, 0, 2'd0, od_a, 4'hF, 8'd1,  "R3 R1 unmasked 128");
    send(pattern(4), 8'h00,        0, 1, 2'd1, od_a, 4'hF, 8'h80, "R3 R1 unmasked 256");
    send(pattern(5), 8'hFF,        1, 0, 2'd0, od_a, 4'hF, 8'h7F, "R9 R6 upper mask ignored 128");
    send(pattern(6), 8'b1111_0010, 1, 1, 2'd1, od_b, 4'hF, 8'd0,  "R9 R6 upper mask ignored 256");
    send(pattern(7), 8'h00,        1, 0, 2'd2, od_a, 4'hF, 8'd5,  "R12 empty mask merge");
    send(pattern(8), 8'h00,        1, 1, 2'd1, od_a, 4'hF, 8'd5,  "R12 empty mask zero");
    send(pattern(9), 8'b0110_1001, 1, 0, 2'd3, od_b, 4'hF, 8'hF0, "R1 code 3 is 512");
    send(pattern(10), 8'hFF,       1, 0, 2'd0, od_b, 4'h7, 8'd2,  "R7 illegal short length");
    send(pattern(11), 8'h0F,       0, 1, 2'd2, od_a, 4'h0, 8'hC0, "R7 illegal full length");
    idle(1);
    send(pattern(12), 8'b1000_0000, 1, 0, 2'd2, od_a, 4'hF, 8'd9, "R2 top lane only");
    send(pattern(13), 8'b0000_0011, 1, 0, 2'd0, od_a, 4'hF, 8'd4, "R10 all active set 128");
    idle(4);
    // R11 outputs held and strobe is one cycle
    check(out_valid == 1'b0, "R11 strobe low when idle", $sformatf("%0d", out_valid), "0");
    check(result == last_exp.res && consumed == last_exp.cnt, "R11 outputs held",
          $sformatf("%0d", consumed), $sformatf("%0d", last_exp.cnt));
    check(seen == sent && q.size() == 0, "R11 one result per request",
          $sformatf("%0d", seen), $sformatf("%0d", sent));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule